// File: doc/BRIEF.md
# Indexed Block-Transfer I2C Register Target

This block is an I2C target (no controller role) that holds eight 8-bit control registers. A host writes a contiguous run of registers by naming a starting offset, then a byte count, then the data. It reads a run by naming the offset in a write phase and then issuing a repeated start with the read address. In a read, the target first returns a count byte and then the register contents from the chosen offset onward. The low nibble of register 0 drives four clock-output enable lines.

SCL and SDA come in as plain levels. SDA is driven through an open-drain enable: a 1 on `sda_oe_o` pulls the line low. Both inputs are brought into the system clock domain by two flops and a stability filter. START and STOP are detected on the filtered levels. The internal reset is asserted asynchronously and released on the clock.

Top module: `i2c_blkreg_target`

## Requirements
- R1: The target answers only to 7-bit address 0x69 (address byte 0xD2 for write, 0xD3 for read) by pulling SDA low in the ACK slot. Any other address gets no ACK, and SDA stays released until the next START.
- R2: In a write transfer, the byte after the address is the register offset and the next byte is the data count. Each following data byte that is accepted is ACKed and stored at the current offset, and the offset then advances by one.
- R3: Data bytes beyond the count are NACKed and leave every register unchanged. A count of 0 accepts no data byte.
- R4: Offsets are taken modulo 8 (the offset byte's bits 2:0 select the register). Advancing past offset 7 goes to offset 0, in both writes and reads.
- R5: A read transfer is address 0xD2, offset, repeated START, then 0xD3. The target first sends a count byte of 0x08 and then registers from the offset onward, MSB first, for as long as the host ACKs. A host NACK ends the transfer.
- R6: `clk_en_o[3:0]` equals register 0 bits 3:0 (bit 3 enables output 5, bit 2 output 6, bit 1 output 7, bit 0 output 8; 1 = enabled). These bits reset to 1111.
- R7: Register 6 is the identity byte and resets to 0x01 (revision nibble 0 in bits 7:4, vendor nibble 1 in bits 3:0). Writes to it are ACKed and advance the offset, but its value does not change.
- R8: Registers 1 to 5 and bits 7:4 of register 0 reset to 0, and they store and return any value written to them.
- R9: The target changes SDA only while the filtered SCL is low. START and STOP are SDA falling and rising edges while SCL is high. A STOP returns the target to idle, and a START restarts address reception while keeping the current offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples SCL and SDA |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line level |
| sda_i | input | 1 | I2C data line level (as seen on the wire) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain) |
| clk_en_o | output | 4 | Clock-output enables from register 0 bits 3:0 |

## Verification
The assertions assume a well-behaved host. SDA only moves while SCL is low, except at START and STOP. Each SCL level lasts longer than the two sync flops plus the filter length, so every wire edge reaches the filtered level before the next edge. The bench drives 20-clock SCL phases and changes SDA in the middle of the low phase, far longer than the roughly six-clock input latency. The bench never produces glitches, so the filter is only ever exercised on clean edges.

// File: rtl/i2c_blk_pkg.sv
package i2c_blk_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } xfer_st_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_OFS,
    PH_CNT,
    PH_DATA
  } rx_ph_e;
endpackage

// File: rtl/i2c_pin_filter.sv
module i2c_pin_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic          lvl_q, lvl_d, prev_q;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    lvl_d = lvl_q;
    cnt_d = '0;
    if (sync_q[1] != lvl_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        lvl_d = sync_q[1];
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      lvl_q  <= 1'b1;
      prev_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      lvl_q  <= lvl_d;
      prev_q <= lvl_q;
      cnt_q  <= cnt_d;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = lvl_q & ~prev_q;
  assign fall_o = ~lvl_q & prev_q;

  // R9: filtered level only moves to the value the synchroniser presented
  a_r9_filter_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(sync_q[1])));
endmodule

// File: rtl/i2c_blk_regbank.sv
module i2c_blk_regbank #(
  parameter int          NREGS    = 8,
  parameter int          CTRL_IDX = 0,
  parameter int          ID_IDX   = 6,
  parameter logic [7:0]  CTRL_RST = 8'h0F,
  parameter logic [7:0]  ID_RST   = 8'h01,
  parameter int          OE_W     = 4,
  localparam int         AW       = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  output logic [OE_W-1:0] oe_o
);
  localparam logic [AW-1:0] ID_A = AW'(ID_IDX);

  logic [7:0] regs [NREGS];
  logic       wr_en;

  function automatic logic [7:0] rst_val(input int idx);
    if (idx == CTRL_IDX) return CTRL_RST;
    if (idx == ID_IDX)   return ID_RST;
    return 8'h00;
  endfunction

  assign wr_en = we && (waddr != ID_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= rst_val(i);
    end else if (wr_en) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata = regs[raddr];
  assign oe_o  = regs[CTRL_IDX][OE_W-1:0];

  // R7: a write aimed at the identity byte leaves it as it was
  a_r7_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr == ID_A) |=> $stable(regs[ID_IDX]));
  // R2: an accepted write lands at the addressed register
  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != ID_A) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/i2c_blkreg_target.sv
module i2c_blkreg_target
  import i2c_blk_pkg::*;
#(
  parameter int         NREGS    = 8,
  parameter logic [6:0] SLV_ADDR = 7'h69,
  parameter int         FILT_LEN = 3,
  parameter int         OE_W     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  output logic [OE_W-1:0] clk_en_o
);
  localparam int         AW       = $clog2(NREGS);
  localparam logic [7:0] CNT_BYTE = 8'(NREGS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_int = rst_q[1];

  logic scl_lvl, scl_rise, scl_fall;
  logic sda_lvl, sda_rise, sda_fall;

  i2c_pin_filter #(.FILT_LEN(FILT_LEN)) u_scl (
    .clk(clk), .rst_n(rst_int), .pin_i(scl_i),
    .lvl_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));
  i2c_pin_filter #(.FILT_LEN(FILT_LEN)) u_sda (
    .clk(clk), .rst_n(rst_int), .pin_i(sda_i),
    .lvl_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  logic start_evt, stop_evt;
  assign start_evt = sda_fall & scl_lvl;
  assign stop_evt  = sda_rise & scl_lvl;

  xfer_st_e      state_q, state_d;
  rx_ph_e        phase_q, phase_d;
  logic          rw_q, rw_d;
  logic [3:0]    bitcnt_q, bitcnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [7:0]    remain_q, remain_d;
  logic          mack_q, mack_d;
  logic          oe_q, oe_d;
  logic          reg_we;
  logic [7:0]    rdata;

  i2c_blk_regbank #(.NREGS(NREGS), .OE_W(OE_W)) u_regs (
    .clk(clk), .rst_n(rst_int), .we(reg_we), .waddr(ptr_q), .wdata(shreg_q),
    .raddr(ptr_q), .rdata(rdata), .oe_o(clk_en_o));

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    rw_d     = rw_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    ptr_d    = ptr_q;
    remain_d = remain_q;
    mack_d   = mack_q;
    oe_d     = oe_q;
    reg_we   = 1'b0;
    if (stop_evt) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_evt) begin
      state_d  = ST_RX;
      phase_d  = PH_ADDR;
      bitcnt_d = '0;
      oe_d     = 1'b0;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise && bitcnt_q < 4'd8) begin
            shreg_d  = {shreg_q[6:0], sda_lvl};
            bitcnt_d = bitcnt_q + 1'b1;
          end else if (scl_fall && bitcnt_q == 4'd8) begin
            unique case (phase_q)
              PH_ADDR: begin
                if (shreg_q[7:1] == SLV_ADDR) begin
                  rw_d    = shreg_q[0];
                  oe_d    = 1'b1;
                  state_d = ST_RX_ACK;
                  phase_d = PH_OFS;
                end else begin
                  state_d = ST_WAIT;
                end
              end
              PH_OFS: begin
                ptr_d   = shreg_q[AW-1:0];
                oe_d    = 1'b1;
                state_d = ST_RX_ACK;
                phase_d = PH_CNT;
              end
              PH_CNT: begin
                remain_d = shreg_q;
                oe_d     = 1'b1;
                state_d  = ST_RX_ACK;
                phase_d  = PH_DATA;
              end
              default: begin
                if (remain_q != 8'd0) begin
                  reg_we   = 1'b1;
                  ptr_d    = ptr_q + 1'b1;
                  remain_d = remain_q - 1'b1;
                  oe_d     = 1'b1;
                  state_d  = ST_RX_ACK;
                end else begin
                  state_d = ST_WAIT;
                end
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            bitcnt_d = '0;
            if (rw_q) begin
              state_d = ST_TX;
              shreg_d = CNT_BYTE;
              oe_d    = ~CNT_BYTE[7];
            end else begin
              state_d = ST_RX;
              oe_d    = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt_q == 4'd7) begin
              oe_d    = 1'b0;
              state_d = ST_TX_ACK;
            end else begin
              shreg_d  = {shreg_q[6:0], 1'b0};
              bitcnt_d = bitcnt_q + 1'b1;
              oe_d     = ~shreg_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (mack_q) begin
              shreg_d  = rdata;
              ptr_d    = ptr_q + 1'b1;
              oe_d     = ~rdata[7];
              bitcnt_d = '0;
              state_d  = ST_TX;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      state_q  <= ST_IDLE;
      phase_q  <= PH_ADDR;
      rw_q     <= 1'b0;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      ptr_q    <= '0;
      remain_q <= '0;
      mack_q   <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      phase_q  <= phase_d;
      rw_q     <= rw_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      ptr_q    <= ptr_d;
      remain_q <= remain_d;
      mack_q   <= mack_d;
      oe_q     <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;

  // R9: SDA drive changes only while filtered SCL is low
  a_r9_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_int)
    (oe_q != $past(oe_q)) |-> !$past(scl_lvl));
  // R1: SDA released while idle or ignoring a transfer
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_int)
    (state_q == ST_IDLE || state_q == ST_WAIT) |-> !oe_q);
  // R2: the target's own ACK slot always pulls SDA low
  a_r2_ack_driven: assert property (@(posedge clk) disable iff (!rst_int)
    (state_q == ST_RX_ACK) |-> oe_q);
  // R3: the remaining count shrinks by one per stored byte
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_int)
    reg_we |=> (remain_q == $past(remain_q) - 8'd1));
endmodule

// File: tb/i2c_blkreg_target_test.sv
module i2c_blkreg_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;
  localparam logic [31:0] VEC [6] = '{
    {8'h00, 8'h01, 8'h05, 8'h99},
    {8'h03, 8'h02, 8'hA5, 8'h5A},
    {8'h07, 8'h02, 8'hC3, 8'h3C},
    {8'h06, 8'h02, 8'hFF, 8'h77},
    {8'h01, 8'h00, 8'h11, 8'h22},
    {8'h09, 8'h01, 8'h6D, 8'h44}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl;
  logic       m_low;
  logic       sda_oe;
  logic [3:0] clk_en;
  logic       sda_bus;
  int         n_chk = 0;
  int         n_err = 0;
  logic [7:0] mdl [8];

  assign sda_bus = ~(m_low | sda_oe);

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_blkreg_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .clk_en_o(clk_en));

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_out(input logic b);
    wt(10); m_low = ~b; wt(10); scl = 1'b1; wt(20); scl = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    m_low = 1'b0; wt(20); scl = 1'b1; wt(10); b = sda_bus; wt(10); scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input logic ack, output logic [7:0] d);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      bit_in(x);
      d[i] = x;
    end
    bit_out(~ack);
  endtask

  task automatic i2c_start;
    m_low = 1'b1; wt(20); scl = 1'b0; wt(5);
  endtask

  task automatic i2c_rstart;
    wt(10); m_low = 1'b0; wt(10); scl = 1'b1; wt(20); m_low = 1'b1; wt(20);
    scl = 1'b0; wt(5);
  endtask

  task automatic i2c_stop;
    wt(10); m_low = 1'b1; wt(10); scl = 1'b1; wt(20); m_low = 1'b0; wt(20);
  endtask

  // read n registers from offset off, checking the count byte and contents
  task automatic rd_check(input int off, input int n, input string tag);
    logic       a;
    logic [7:0] d;
    int         p;
    i2c_start;
    send_byte(8'hD2, a); chk({tag, " R1 wr-addr ack"}, a, 1);
    send_byte(8'(off), a); chk({tag, " R2 offset ack"}, a, 1);
    i2c_rstart;
    send_byte(8'hD3, a); chk({tag, " R1 rd-addr ack"}, a, 1);
    recv_byte(1'b1, d); chk({tag, " R5 count byte"}, d, 8'h08);
    p = off % 8;
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk({tag, " R5 R4 data"}, d, mdl[p]);
      p = (p + 1) % 8;
    end
    i2c_stop;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic       a;
    logic [7:0] d;
    int         p;
    scl = 1'b1; m_low = 1'b0; rst_n = 1'b0;
    for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
    mdl[0] = 8'h0F;
    mdl[6] = 8'h01;
    wt(5); rst_n = 1'b1; wt(10);

    // R6: enables all on after reset; R7/R8 reset contents
    chk("R6 reset enables", clk_en, 4'hF);
    rd_check(0, 8, "reset R7 R8");

    // R1: foreign address is not acknowledged and SDA stays released
    i2c_start;
    send_byte(8'hA4, a); chk("R1 foreign addr nack", a, 0);
    send_byte(8'hFF, a); chk("R1 silent after nack", a, 0);
    i2c_stop;

    // table of block writes with readback
    for (int v = 0; v < 6; v++) begin
      logic [7:0] off, cnt;
      logic [7:0] dv [2];
      off = VEC[v][31:24]; cnt = VEC[v][23:16];
      dv[0] = VEC[v][15:8]; dv[1] = VEC[v][7:0];
      i2c_start;
      send_byte(8'hD2, a); chk("R1 write addr ack", a, 1);
      send_byte(off, a);   chk("R2 offset ack", a, 1);
      send_byte(cnt, a);   chk("R2 count ack", a, 1);
      p = off % 8;
      for (int i = 0; i < 2; i++) begin
        send_byte(dv[i], a);
        chk("R3 R2 data ack vs count", a, (i < cnt) ? 1 : 0);
        if (i < cnt) begin
          if (p != 6) mdl[p] = dv[i];   // R7: identity byte ignored
          p = (p + 1) % 8;
        end
        if (!a) break;
      end
      i2c_stop;
      chk("R6 enables follow reg0", clk_en, mdl[0][3:0]);
      rd_check(off, 2, "table R3 R4 R8");
    end

    // R4/R5: read wraps from offset 6 through 7 into 0 and 1
    rd_check(6, 4, "wrap R4");
    // R7: identity still at reset value after attempted write
    chk("R7 identity kept", mdl[6], 8'h01);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule